// File: doc/BRIEF.md
# Next Instruction Address Generator

This block holds the program counter of a 32-bit core with fixed-width instructions and works out where the next fetch goes. Each cycle the decoder tells it what kind of instruction is current: plain sequential, a branch on equal, a branch on not-equal, or an absolute jump. With that come the 16-bit branch displacement, the 26-bit jump field, and an equality flag from the register comparator. From these the block picks one of three addresses: the incremented PC, a PC-relative branch target or a region-local jump target. It loads that address into the PC on the next clock edge.

Updates happen only while the advance enable is high, so a stalled fetch holds its address. A synchronous reset puts the PC at the start of user code, 0x0040_0000. Two outputs leave the block. One is the byte address in the PC. The other is the matching word index, used to read a word-organised instruction store.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC loads 0x0040_0000. This happens whatever the state of `adv_en` and the other inputs.
- R2: When `flow_sel` is 0 (sequential) and `adv_en` is high, the PC becomes PC+4. `regs_eq`, `br_off` and `jfield` have no effect.
- R3: When `flow_sel` is 1 (branch on equal), `regs_eq` is 1 and `adv_en` is high, the PC becomes PC+4 plus the sign-extended `br_off` multiplied by 4.
- R4: When `flow_sel` is 2 (branch on not-equal), `regs_eq` is 0 and `adv_en` is high, the PC becomes PC+4 plus the sign-extended `br_off` multiplied by 4.
- R5: A branch whose condition fails (code 1 with `regs_eq`=0, or code 2 with `regs_eq`=1) loads PC+4. The internal taken flag is only ever set for the two branch codes.
- R6: When `flow_sel` is 3 (jump) and `adv_en` is high, the PC becomes {bits 31:28 of PC+4, `jfield`, 2'b00}. The region bits come from PC+4, not from the current PC.
- R7: While `adv_en` is low and `rst` is low, the PC keeps its value.
- R8: `fetch_addr` is always bits 31:2 of the PC, the index of the 4-byte word it addresses. During a sequential advance it goes up by exactly 1.
- R9: Bits 1:0 of the PC are always zero. A negative displacement (bit 15 set, including the extreme 0x8000) moves the PC backwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | PC update enable; low stalls fetch |
| flow_sel | input | 2 | Instruction class: 0 sequential, 1 branch-equal, 2 branch-not-equal, 3 jump |
| br_off | input | 16 | Signed branch displacement in words |
| jfield | input | 26 | Jump target word field |
| regs_eq | input | 1 | 1 when the two compared registers are equal |
| pc_q | output | 32 | Current program counter, byte address |
| fetch_addr | output | 30 | Word index of the current PC |

## Verification
The bench drives each branch polarity both ways. A design with the branch sense swapped, or one that treats a failed branch as taken, then lands on the wrong address at once. Displacements of 0x7FFF and 0x8000 catch a zero-extended offset or one added without the shift by two. One jump sits on the last word of a 256 MiB region, so its PC+4 crosses into the next region; a design that took the region bits from the current PC would stay in the old region. Stalls with jump inputs present and a reset asserted while stalled show whether enable and reset take precedence over the selected target.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int ADDR_W     = 32;
  localparam int OFF_W      = 16;
  localparam int JF_W       = 26;
  localparam int ALIGN_BITS = 2;
  localparam int INSN_BYTES = 1 << ALIGN_BITS;
  localparam int WORD_W     = ADDR_W - ALIGN_BITS;
  localparam int SEXT_W     = ADDR_W - OFF_W - ALIGN_BITS;
  localparam int REGION_W   = ADDR_W - JF_W - ALIGN_BITS;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    FLOW_SEQ = 2'd0,
    FLOW_BEQ = 2'd1,
    FLOW_BNE = 2'd2,
    FLOW_JMP = 2'd3
  } flow_t;

  function automatic addr_t seq_next(input addr_t pc);
    return pc + addr_t'(INSN_BYTES);
  endfunction

  function automatic addr_t branch_target(input addr_t p4, input logic [OFF_W-1:0] off);
    addr_t disp;
    disp = {{SEXT_W{off[OFF_W-1]}}, off, {ALIGN_BITS{1'b0}}};
    return p4 + disp;
  endfunction

  function automatic addr_t jump_target(input addr_t p4, input logic [JF_W-1:0] jf);
    return {p4[ADDR_W-1 -: REGION_W], jf, {ALIGN_BITS{1'b0}}};
  endfunction

  function automatic logic cond_taken(input flow_t f, input logic eq);
    case (f)
      FLOW_BEQ: return eq;
      FLOW_BNE: return ~eq;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/npc_targets.sv
module npc_targets
  import npc_pkg::*;
(
  input  addr_t             pc,
  input  logic [OFF_W-1:0]  off,
  input  logic [JF_W-1:0]   jf,
  output addr_t             pc_plus4,
  output addr_t             br_tgt,
  output addr_t             jmp_tgt
);

  always_comb begin
    pc_plus4 = seq_next(pc);
    br_tgt   = branch_target(pc_plus4, off);
    jmp_tgt  = jump_target(pc_plus4, jf);
  end

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  flow_t flow,
  input  logic  eq,
  input  addr_t pc_plus4,
  input  addr_t br_tgt,
  input  addr_t jmp_tgt,
  output logic  br_taken,
  output addr_t nxt_pc
);

  always_comb begin
    br_taken = cond_taken(flow, eq);
    if (flow == FLOW_JMP)
      nxt_pc = jmp_tgt;
    else if (br_taken)
      nxt_pc = br_tgt;
    else
      nxt_pc = pc_plus4;
  end

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
  import npc_pkg::*;
#(
  parameter addr_t RESET_VEC = 32'h0040_0000
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  addr_t d,
  output addr_t q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= RESET_VEC;
    else if (en)
      q <= d;
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic [1:0]        flow_sel,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [JF_W-1:0]   jfield,
  input  logic              regs_eq,
  output logic [ADDR_W-1:0] pc_q,
  output logic [WORD_W-1:0] fetch_addr
);

  addr_t pc_plus4;
  addr_t br_tgt;
  addr_t jmp_tgt;
  addr_t nxt_pc;
  logic  br_taken;
  flow_t flow;

  assign flow = flow_t'(flow_sel);

  npc_targets u_tgt (
    .pc       (pc_q),
    .off      (br_off),
    .jf       (jfield),
    .pc_plus4 (pc_plus4),
    .br_tgt   (br_tgt),
    .jmp_tgt  (jmp_tgt)
  );

  npc_select u_sel (
    .flow     (flow),
    .eq       (regs_eq),
    .pc_plus4 (pc_plus4),
    .br_tgt   (br_tgt),
    .jmp_tgt  (jmp_tgt),
    .br_taken (br_taken),
    .nxt_pc   (nxt_pc)
  );

  npc_pc_reg #(.RESET_VEC(RESET_VEC)) u_pc (
    .clk (clk),
    .rst (rst),
    .en  (adv_en),
    .d   (nxt_pc),
    .q   (pc_q)
  );

  assign fetch_addr = pc_q[ADDR_W-1:ALIGN_BITS];

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              adv_en,
  input logic [1:0]        flow_sel,
  input logic [OFF_W-1:0]  br_off,
  input logic [JF_W-1:0]   jfield,
  input logic              regs_eq,
  input logic [ADDR_W-1:0] pc_q,
  input logic [WORD_W-1:0] fetch_addr,
  input logic              br_taken
);

  logic rst_d = 1'b0;
  logic [ADDR_W-1:0] disp_c;
  logic [ADDR_W-1:0] p4_c;

  assign disp_c = ADDR_W'($signed(br_off)) << ALIGN_BITS;
  assign p4_c   = pc_q + ADDR_W'(INSN_BYTES);

  always @(posedge clk) begin
    // R1
    if (rst_d)
      reset_vec_chk: assert (pc_q == RESET_VEC);
    rst_d <= rst;
  end

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && flow_sel == FLOW_SEQ) |=> (pc_q == $past(p4_c)));

  // R3
  beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && flow_sel == FLOW_BEQ && regs_eq) |=> (pc_q == $past(p4_c + disp_c)));

  // R4
  bne_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && flow_sel == FLOW_BNE && !regs_eq) |=> (pc_q == $past(p4_c + disp_c)));

  // R5
  fall_through_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && ((flow_sel == FLOW_BEQ && !regs_eq) || (flow_sel == FLOW_BNE && regs_eq)))
      |=> (pc_q == $past(p4_c)));

  // R5
  taken_class_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (flow_sel == FLOW_BEQ || flow_sel == FLOW_BNE));

  // R6
  jump_region_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && flow_sel == FLOW_JMP)
      |=> (pc_q[ADDR_W-1 -: REGION_W] == $past(p4_c[ADDR_W-1 -: REGION_W]))
          && (pc_q[ALIGN_BITS +: JF_W] == $past(jfield)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(pc_q));

  // R8
  word_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && flow_sel == FLOW_SEQ) |=> (fetch_addr == $past(fetch_addr) + 1'b1));

  // R9
  align_chk: assert property (@(posedge clk) disable iff (rst)
    pc_q[ALIGN_BITS-1:0] == '0);

endmodule

bind npc_unit npc_unit_chk #(.RESET_VEC(RESET_VEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .adv_en     (adv_en),
  .flow_sel   (flow_sel),
  .br_off     (br_off),
  .jfield     (jfield),
  .regs_eq    (regs_eq),
  .pc_q       (pc_q),
  .fetch_addr (fetch_addr),
  .br_taken   (br_taken)
);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VEC = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic [1:0]  flow_sel = 2'd0;
  logic [15:0] br_off = 16'd0;
  logic [25:0] jfield = 26'd0;
  logic        regs_eq = 1'b0;
  logic [31:0] pc_q;
  logic [29:0] fetch_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_pc = VEC;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit u0 (
    .clk        (clk),
    .rst        (rst),
    .adv_en     (adv_en),
    .flow_sel   (flow_sel),
    .br_off     (br_off),
    .jfield     (jfield),
    .regs_eq    (regs_eq),
    .pc_q       (pc_q),
    .fetch_addr (fetch_addr)
  );

  task automatic step(input logic r, input logic e, input logic [1:0] f,
                      input logic [15:0] o, input logic [25:0] j,
                      input logic q, input string tag);
    logic [31:0] p4;
    logic signed [31:0] so;
    @(negedge clk);
    rst = r; adv_en = e; flow_sel = f; br_off = o; jfield = j; regs_eq = q;
    p4 = m_pc + 32'd4;
    so = 32'($signed(o));
    if (r) m_pc = VEC;
    else if (!e) m_pc = m_pc;
    else if (f == 2'd3) m_pc = {p4[31:28], j, 2'b00};
    else if ((f == 2'd1 && q) || (f == 2'd2 && !q)) m_pc = p4 + 32'(so * 32'sd4);
    else m_pc = p4;
    exp_q.push_back(m_pc);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    logic [31:0] e;
    string t;
    #2;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pc_q !== e) begin
        failures++;
        $display("FAIL %s pc actual=%h expected=%h", t, pc_q, e);
      end
      checks++;
      if (fetch_addr !== e[31:2]) begin
        failures++;
        $display("FAIL R8 (%s) fetch_addr actual=%h expected=%h", t, fetch_addr, e[31:2]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(1, 0, 2'd0, 16'h0000, 26'h0, 0, "R1 reset");
    step(1, 1, 2'd3, 16'h0000, 26'h155, 1, "R1 reset over jump");
    step(0, 1, 2'd0, 16'h0000, 26'h0, 0, "R2 seq");
    step(0, 1, 2'd0, 16'hFFFF, 26'h3FFFFFF, 1, "R2 seq ignores fields");
    step(0, 1, 2'd0, 16'h1234, 26'h0ABCDEF, 0, "R2 seq");
    step(0, 1, 2'd1, 16'h0003, 26'h0, 1, "R3 beq taken fwd");
    step(0, 1, 2'd1, 16'h0040, 26'h0, 0, "R5 beq not taken");
    step(0, 1, 2'd2, 16'hFFFE, 26'h0, 0, "R4 bne taken back");
    step(0, 1, 2'd2, 16'h0100, 26'h0, 1, "R5 bne not taken");
    step(0, 1, 2'd1, 16'h7FFF, 26'h0, 1, "R3 max positive offset");
    step(0, 1, 2'd2, 16'h8000, 26'h0, 0, "R9 most negative offset");
    step(0, 1, 2'd3, 16'h0000, 26'h0100010, 0, "R6 jump");
    step(0, 0, 2'd3, 16'h0000, 26'h3000000, 1, "R7 stall with jump");
    step(0, 0, 2'd1, 16'h0010, 26'h0, 1, "R7 stall with beq");
    step(0, 1, 2'd3, 16'h0000, 26'h3FFFFFF, 0, "R6 jump to region end");
    step(0, 1, 2'd3, 16'h0000, 26'h0000005, 0, "R6 region from pc+4");
    step(0, 1, 2'd0, 16'h0000, 26'h0, 0, "R8 seq word step");
    step(0, 1, 2'd2, 16'hFFFF, 26'h0, 0, "R9 backward by one");
    step(1, 0, 2'd0, 16'h0000, 26'h0, 0, "R1 reset while stalled");
    step(0, 1, 2'd1, 16'hFFFC, 26'h0, 1, "R9 beq back from vector");
    step(0, 1, 2'd0, 16'h0000, 26'h0, 0, "R2 seq after branch");
    @(negedge clk);
    adv_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule